// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for the host-facing command logic of a serial keyboard sitting on one channel of a serial controller. The host writes command bytes toward the keyboard; the block decodes them and places reply bytes into a receive queue. The host drains that queue through a read port. An available flag is high whenever at least one byte is waiting.

Two commands clear the queue and then load a fixed reply: an identify/reset reply of three bytes and a layout reply of two bytes. A small sequencer pushes the reply one byte per clock. It holds off further commands with a ready signal while it runs. An LED-setting command produces no reply. Instead, it marks the next accepted byte as its parameter, and that byte is consumed without being decoded. Commands are only taken when the enable input is high. The enable input combines "transmitter enabled" and "device not disabled".

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset, avail_o is 0, rd_data_o is 0x00 and cmd_ready_o is 1.
- R2: Command 0x01 empties the queue, then enqueues 0xFF, 0x04, 0x7F in that order.
- R3: Commands 0x07 and 0x0F each empty the queue, then enqueue 0xFE, 0x00 in that order.
- R4: Bytes queued before a 0x01, 0x07 or 0x0F command are discarded by it and are never read.
- R5: Command 0x0E adds nothing to the queue. The next accepted byte is consumed as its parameter with no effect, even if that byte is 0x01, 0x07 or 0x0F.
- R6: Any other command byte leaves the queue contents and avail_o unchanged.
- R7: A byte presented while enable_i is 0 has no effect. It does not change the queue, and it does not consume a pending LED parameter slot.
- R8: The queue holds DEPTH bytes (default 256). A reply byte pushed while the queue is full is dropped.
- R9: A read of an empty queue returns 0x00 and changes nothing. rd_data_o always shows the oldest queued byte, and a read pulse removes it.
- R10: avail_o is 1 exactly when the queue holds at least one byte. It stays high after a read while bytes remain.
- R11: A command is accepted on a clock edge where cmd_valid_i, cmd_ready_o and enable_i are all 1. After an accepted 0x01, cmd_ready_o is 0 for three cycles, one reply byte entering per cycle. After an accepted 0x07 or 0x0F, it is 0 for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Command byte from host |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_ready_o | output | 1 | Block can take a command |
| enable_i | input | 1 | Transmitter enabled and device not disabled |
| rd_i | input | 1 | Read strobe, pops one byte |
| rd_data_o | output | 8 | Oldest queued byte, 0x00 when empty |
| avail_o | output | 1 | Queue is non-empty |

## Verification
The checker watches the port-level invariants on every cycle:
- an empty read returns zero;
- bytes appear only while a reply is being pushed, and a busy cycle always leaves data queued;
- a disabled command never starts a reply;
- the busy window never exceeds three cycles.

The bench scenarios are the only place that shows the exact reply bytes and their order. They also show that a flush discards earlier data, that the LED parameter byte is swallowed even when disabled bytes come between, and that a queue-full push is dropped. The drop is shown on a second, two-entry instance.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam logic [7:0] CMD_IDENT  = 8'h01;
  localparam logic [7:0] CMD_LAYOUT = 8'h07;
  localparam logic [7:0] CMD_LAYALT = 8'h0F;
  localparam logic [7:0] CMD_LED    = 8'h0E;

  typedef enum logic {RPL_IDENT, RPL_LAYOUT} reply_e;

  function automatic logic [1:0] reply_last(reply_e k);
    return (k == RPL_IDENT) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [7:0] reply_byte(reply_e k, logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (k == RPL_IDENT) begin
      case (idx)
        2'd0:    b = 8'hFF;
        2'd1:    b = 8'h04;
        default: b = 8'h7F;
      endcase
    end else begin
      b = (idx == 2'd0) ? 8'hFE : 8'h00;
    end
    return b;
  endfunction
endpackage

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic       cmd_valid_i,
  input  logic       enable_i,
  output logic       ready_o,
  output logic       flush_o,
  output logic       push_o,
  output logic [7:0] push_data_o
);
  logic       busy_q, led_skip_q;
  reply_e     kind_q;
  logic [1:0] idx_q;
  logic       accept, start;
  reply_e     start_kind;

  assign ready_o = ~busy_q;
  assign accept  = cmd_valid_i & ~busy_q & enable_i;

  always_comb begin
    start      = 1'b0;
    start_kind = RPL_IDENT;
    if (accept && !led_skip_q) begin
      case (cmd_i)
        CMD_IDENT:              start = 1'b1;
        CMD_LAYOUT, CMD_LAYALT: begin start = 1'b1; start_kind = RPL_LAYOUT; end
        default: ;
      endcase
    end
  end

  assign flush_o     = start;
  assign push_o      = busy_q;
  assign push_data_o = reply_byte(kind_q, idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      led_skip_q <= 1'b0;
      kind_q     <= RPL_IDENT;
      idx_q      <= '0;
    end else begin
      if (accept) begin
        if (led_skip_q)             led_skip_q <= 1'b0;
        else if (cmd_i == CMD_LED)  led_skip_q <= 1'b1;
      end
      if (start) begin
        busy_q <= 1'b1;
        kind_q <= start_kind;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (idx_q == reply_last(kind_q)) busy_q <= 1'b0;
        else                             idx_q  <= idx_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/kbd_rx_queue.sv
module kbd_rx_queue #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          nonempty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign do_pop     = pop_i & (cnt_q != '0);
  assign do_push    = push_i & (cnt_q != FULL);
  assign nonempty_o = (cnt_q != '0);
  assign head_o     = nonempty_o ? mem_q[rptr_q] : '0;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
  parameter int DEPTH = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic       enable_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       avail_o
);
  logic       flush, push;
  logic [7:0] push_data;

  kbd_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .cmd_valid_i (cmd_valid_i),
    .enable_i    (enable_i),
    .ready_o     (cmd_ready_o),
    .flush_o     (flush),
    .push_o      (push),
    .push_data_o (push_data)
  );

  kbd_rx_queue #(.DEPTH(DEPTH), .DW(8)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (rd_i),
    .head_o      (rd_data_o),
    .nonempty_o  (avail_o)
  );
endmodule

// File: rtl/kbd_cmd_responder_chk.sv
module kbd_cmd_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       enable_i,
  input logic       rd_i,
  input logic [7:0] rd_data_o,
  input logic       avail_o
);
  // R9
  empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !avail_o) |-> (rd_data_o == 8'h00));

  // R10
  busy_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |=> avail_o);

  // R6
  no_spurious_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avail_o && cmd_ready_o) |=> !avail_o);

  // R7
  disabled_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !enable_i) |=> cmd_ready_o);

  // R11
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_ready_o && $past(!cmd_ready_o) && $past(!cmd_ready_o, 2)) |=> cmd_ready_o);

  // R11
  idle_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !cmd_valid_i) |=> cmd_ready_o);
endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .enable_i    (enable_i),
  .rd_i        (rd_i),
  .rd_data_o   (rd_data_o),
  .avail_o     (avail_o)
);

// File: tb/kbd_cmd_responder_tb_top.sv
`timescale 1ns/1ps
module kbd_cmd_responder_tb_top;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       cmd_valid = 1'b0;
  logic       enable = 1'b1;
  logic       rd = 1'b0;
  logic       ready, avail, ready_s, avail_s;
  logic [7:0] rd_data, rd_data_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  kbd_cmd_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_valid_i(cmd_valid),
    .cmd_ready_o(ready), .enable_i(enable), .rd_i(rd),
    .rd_data_o(rd_data), .avail_o(avail));

  kbd_cmd_responder #(.DEPTH(2)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_valid_i(cmd_valid),
    .cmd_ready_o(ready_s), .enable_i(enable), .rd_i(rd),
    .rd_data_o(rd_data_s), .avail_o(avail_s));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one byte; waits for ready, then lets any reply finish
  task automatic send(logic [7:0] c, logic en);
    @(negedge clk);
    cmd = c; enable = en; cmd_valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; enable = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_expect(string req, logic [7:0] exp, logic exp_avail);
    chk(req, {7'd0, avail}, {7'd0, exp_avail});
    chk(req, rd_data, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic drain();
    while (avail) begin
      rd = 1'b1;
      @(negedge clk);
    end
    rd = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 avail", {7'd0, avail}, 8'h00);
    chk("R1 data",  rd_data, 8'h00);
    chk("R1 ready", {7'd0, ready}, 8'h01);
  endtask

  task automatic t_ident();
    send(8'h01, 1'b1);
    pop_expect("R2 byte0", 8'hFF, 1'b1);
    pop_expect("R2 byte1", 8'h04, 1'b1);
    pop_expect("R10 byte2 avail kept", 8'h7F, 1'b1);
    chk("R10 empty after drain", {7'd0, avail}, 8'h00);
  endtask

  task automatic t_layout();
    send(8'h07, 1'b1);
    pop_expect("R3 07 b0", 8'hFE, 1'b1);
    pop_expect("R3 07 b1", 8'h00, 1'b1);
    chk("R3 07 empty", {7'd0, avail}, 8'h00);
    send(8'h0F, 1'b1);
    pop_expect("R3 0F b0", 8'hFE, 1'b1);
    pop_expect("R3 0F b1", 8'h00, 1'b1);
    chk("R3 0F empty", {7'd0, avail}, 8'h00);
  endtask

  task automatic t_flush();
    send(8'h01, 1'b1);
    pop_expect("R4 prefix", 8'hFF, 1'b1);
    send(8'h0F, 1'b1);
    pop_expect("R4 new b0", 8'hFE, 1'b1);
    pop_expect("R4 new b1", 8'h00, 1'b1);
    chk("R4 old gone", {7'd0, avail}, 8'h00);
  endtask

  task automatic t_led();
    send(8'h0E, 1'b1);
    chk("R5 no reply", {7'd0, avail}, 8'h00);
    send(8'h01, 1'b1);
    chk("R5 param swallowed", {7'd0, avail}, 8'h00);
    send(8'h07, 1'b1);
    pop_expect("R5 decoding resumes", 8'hFE, 1'b1);
    drain();
  endtask

  task automatic t_ignore();
    send(8'h01, 1'b1);
    send(8'h55, 1'b1);
    send(8'h00, 1'b1);
    send(8'hFF, 1'b1);
    pop_expect("R6 b0", 8'hFF, 1'b1);
    pop_expect("R6 b1", 8'h04, 1'b1);
    pop_expect("R6 b2", 8'h7F, 1'b1);
    chk("R6 empty", {7'd0, avail}, 8'h00);
  endtask

  task automatic t_disable();
    send(8'h01, 1'b0);
    chk("R7 disabled no reply", {7'd0, avail}, 8'h00);
    send(8'h0E, 1'b1);
    send(8'h01, 1'b0);
    send(8'h07, 1'b0);
    chk("R7 still empty", {7'd0, avail}, 8'h00);
    send(8'h01, 1'b1);
    chk("R7 param slot kept", {7'd0, avail}, 8'h00);
    send(8'h07, 1'b1);
    pop_expect("R7 after param", 8'hFE, 1'b1);
    drain();
  endtask

  task automatic t_overflow();
    send(8'h01, 1'b1);
    chk("R8 small b0", rd_data_s, 8'hFF);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R8 small b1", rd_data_s, 8'h04);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R8 third dropped", {7'd0, avail_s}, 8'h00);
    chk("R8 big keeps third", rd_data, 8'h7F);
    drain();
  endtask

  task automatic t_empty_read();
    pop_expect("R9 empty read", 8'h00, 1'b0);
    chk("R9 still empty", {7'd0, avail}, 8'h00);
    chk("R9 ready", {7'd0, ready}, 8'h01);
  endtask

  task automatic t_timing();
    @(negedge clk);
    cmd = 8'h01; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 busy c1", {7'd0, ready}, 8'h00);
    chk("R11 flushed c1", {7'd0, avail}, 8'h00);
    @(negedge clk);
    chk("R11 busy c2", {7'd0, ready}, 8'h00);
    chk("R11 first byte", {7'd0, avail}, 8'h01);
    @(negedge clk);
    chk("R11 busy c3", {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk("R11 ready back", {7'd0, ready}, 8'h01);
    drain();
    @(negedge clk);
    cmd = 8'h07; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 layout busy c1", {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk("R11 layout busy c2", {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk("R11 layout ready", {7'd0, ready}, 8'h01);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_ident();
    t_layout();
    t_flush();
    t_led();
    t_ignore();
    t_disable();
    t_overflow();
    t_empty_read();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule